// File: doc/BRIEF.md
# Interval Match Timer Counter

This block is an 8-bit general-purpose timer/counter. It takes a one-cycle tick strobe from the CPU clock domain and divides it by a prescaler. The division is chosen at run time as 4096, 256 or 8, and a fourth setting halts counting. On each divided count the counter advances by one.

In interval match mode the counter is compared against a reference register. When they are equal, the counter returns to zero and a match request may be raised. In the other modes the counter runs freely. A wrap from the all-ones value to zero may raise an overflow request. Software reaches the counter, the reference and the control register through a simple single-cycle write port and a combinational read port.

Register map: address 0 is the counter, 1 the reference, 2 the control register, and 3 is unused. The control fields are:

- bits 7..6: clock select. 00 is /4096, 01 is /256, 10 is /8 and 11 is halt.
- bits 5..4: mode. 00 is interval match; any other value is free-running.
- bit 3: clear strobe.
- bit 1: overflow request enable.
- bit 0: match request enable.

Top module: `interval_match_timer`

## Requirements
- R1: After reset the control register reads 00h (÷4096, interval match mode, both requests off), the counter reads 00h, the reference reads FFh, and both request outputs are low.
- R2: With tick high every cycle, clock-select codes 00, 01 and 10 advance the counter once every 4096, 256 and 8 ticks respectively, counted from a clear.
- R3: Clock-select code 11 holds the counter at its value while it is not written.
- R4: In mode 00 a count that finds the counter equal to the reference loads 00h instead of incrementing. Mode values 01, 10 and 11 never perform this match clear.
- R5: The match request rises in the cycle after that match count only when control bit 0 was set; otherwise it stays low.
- R6: A count from FFh to 00h that is not a match clear raises the overflow request in the following cycle only when control bit 1 was set.
- R7: Writing control with bit 3 set zeroes the counter and prescaler in the same edge, and this takes priority over a count. Control bits 3 and 2 always read 0.
- R8: A write to address 0 loads the counter, taking priority over a count. Address 1 is the reference register, with read/write access. Address 3 reads 00h and writes to it change nothing.
- R9: Each request output is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaler advance strobe |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| match_irq_o | output | 1 | Match request pulse |
| ovf_irq_o | output | 1 | Overflow request pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and prescaler taps at 12, 8 and 3 bits. Two properties of that configuration matter for coverage. Wraps from FFh and matches against small reference values come within a few thousand cycles at the ÷8 tap. One full ÷4096 period fits in a directed run. Random register traffic then mixes loads, clears and mode changes with every tap while counts are in flight.

// File: rtl/itm_pkg.sv
package itm_pkg;

    typedef enum logic [1:0] {
        SEL_SLOW = 2'b00,
        SEL_MID  = 2'b01,
        SEL_FAST = 2'b10,
        SEL_HALT = 2'b11
    } clk_sel_e;

    typedef enum logic [1:0] {
        ADR_COUNT = 2'd0,
        ADR_CMP   = 2'd1,
        ADR_CTRL  = 2'd2,
        ADR_NONE  = 2'd3
    } reg_adr_e;

    typedef struct packed {
        clk_sel_e   sel;
        logic [1:0] mode;
        logic       ovf_en;
        logic       match_en;
    } ctrl_t;

    localparam logic [1:0] MODE_INTERVAL = 2'b00;
    localparam int         CTL_CLR_BIT   = 3;

endpackage

// File: rtl/itm_prescaler.sv
module itm_prescaler
    import itm_pkg::*;
#(
    parameter int SLOW_LOG = 12,
    parameter int MID_LOG  = 8,
    parameter int FAST_LOG = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick_i,
    input  logic     clr_i,
    input  clk_sel_e sel_i,
    output logic     pulse_o
);
    localparam int PRE_W   = SLOW_LOG;
    localparam int NUM_TAP = 3;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [NUM_TAP-1:0] tap_hit;

    for (genvar g = 0; g < NUM_TAP; g++) begin : g_tap
        localparam int L = (g == 0) ? SLOW_LOG : ((g == 1) ? MID_LOG : FAST_LOG);
        assign tap_hit[g] = &s_q.pre[L-1:0];
    end

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.pre = '0;
        end else if (tick_i) begin
            s_d.pre = s_q.pre + 1'b1;
        end
        case (sel_i)
            SEL_SLOW: pulse_o = tick_i && tap_hit[0];
            SEL_MID:  pulse_o = tick_i && tap_hit[1];
            SEL_FAST: pulse_o = tick_i && tap_hit[2];
            default:  pulse_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/itm_counter.sv
module itm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             match_mode_i,
    input  logic             match_en_i,
    input  logic             ovf_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_irq_o,
    output logic             ovf_irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mirq;
        logic             oirq;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.mirq = 1'b0;
        s_d.oirq = 1'b0;
        if (clr_i) begin
            s_d.cnt = '0;
        end else if (load_i) begin
            s_d.cnt = load_val_i;
        end else if (pulse_i) begin
            if (match_mode_i && (s_q.cnt == cmp_i)) begin
                s_d.cnt  = '0;
                s_d.mirq = match_en_i;
            end else begin
                s_d.cnt  = s_q.cnt + 1'b1;
                s_d.oirq = ovf_en_i && (s_q.cnt == CNT_MAX);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o       = s_q.cnt;
    assign match_irq_o = s_q.mirq;
    assign ovf_irq_o   = s_q.oirq;

endmodule

// File: rtl/itm_regs.sv
module itm_regs
    import itm_pkg::*;
#(
    parameter int               DATA_W  = 8,
    parameter logic [DATA_W-1:0] CMP_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] cmp_o,
    output logic              clr_o,
    output logic              load_o
);
    typedef struct packed {
        ctrl_t             ctl;
        logic [DATA_W-1:0] cmp;
    } reg_state_t;

    reg_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        clr_o  = 1'b0;
        load_o = 1'b0;
        if (wr_i) begin
            case (reg_adr_e'(addr_i))
                ADR_COUNT: load_o = 1'b1;
                ADR_CMP:   s_d.cmp = wdata_i;
                ADR_CTRL: begin
                    s_d.ctl.sel      = clk_sel_e'(wdata_i[7:6]);
                    s_d.ctl.mode     = wdata_i[5:4];
                    s_d.ctl.ovf_en   = wdata_i[1];
                    s_d.ctl.match_en = wdata_i[0];
                    clr_o            = wdata_i[CTL_CLR_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctl <= '0;
            s_q.cmp <= CMP_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o = s_q.ctl;
    assign cmp_o  = s_q.cmp;

endmodule

// File: rtl/interval_match_timer.sv
module interval_match_timer
    import itm_pkg::*;
#(
    parameter int SLOW_LOG = 12,
    parameter int MID_LOG  = 8,
    parameter int FAST_LOG = 3,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic             match_irq_o,
    output logic             ovf_irq_o
);
    ctrl_t            ctl_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             clr_s;
    logic             load_s;
    logic             pulse_s;

    itm_regs #(.DATA_W(CNT_W), .CMP_RST({CNT_W{1'b1}})) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .ctrl_o  (ctl_q),
        .cmp_o   (cmp_q),
        .clr_o   (clr_s),
        .load_o  (load_s)
    );

    itm_prescaler #(.SLOW_LOG(SLOW_LOG), .MID_LOG(MID_LOG), .FAST_LOG(FAST_LOG)) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .clr_i   (clr_s),
        .sel_i   (ctl_q.sel),
        .pulse_o (pulse_s)
    );

    itm_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pulse_i      (pulse_s),
        .clr_i        (clr_s),
        .load_i       (load_s),
        .load_val_i   (reg_wdata_i),
        .cmp_i        (cmp_q),
        .match_mode_i (ctl_q.mode == MODE_INTERVAL),
        .match_en_i   (ctl_q.match_en),
        .ovf_en_i     (ctl_q.ovf_en),
        .cnt_o        (cnt_q),
        .match_irq_o  (match_irq_o),
        .ovf_irq_o    (ovf_irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_adr_e'(reg_addr_i))
            ADR_COUNT: reg_rdata_o = cnt_q;
            ADR_CMP:   reg_rdata_o = cmp_q;
            ADR_CTRL:  reg_rdata_o[7:0] = {ctl_q.sel, ctl_q.mode, 2'b00, ctl_q.ovf_en, ctl_q.match_en};
            default:   reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/itm_checker.sv
module itm_checker
    import itm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_i,
    input logic [1:0]       reg_addr_i,
    input logic [CNT_W-1:0] reg_wdata_i,
    input logic [CNT_W-1:0] reg_rdata_o,
    input logic             match_irq_o,
    input logic             ovf_irq_o,
    input ctrl_t            ctl_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_q
);
    // R9
    match_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq_o |=> !match_irq_o);

    // R9
    ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq_o |=> !ovf_irq_o);

    // R5
    match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq_o |-> ($past(ctl_q.match_en) && cnt_q == '0 && $past(cnt_q) == $past(cmp_q)));

    // R6
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq_o |-> ($past(ctl_q.ovf_en) && cnt_q == '0 && $past(cnt_q) == '1));

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.sel == SEL_HALT && !reg_wr_i) |=> $stable(cnt_q));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd2 && reg_wdata_i[CTL_CLR_BIT]) |=> cnt_q == '0);

    // R7
    always_comb begin
        if (rst_n && reg_addr_i == 2'd2) begin
            ctrl_reserved_chk: assert (reg_rdata_o[3:2] == 2'b00);
        end
    end

endmodule

bind interval_match_timer itm_checker #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .match_irq_o (match_irq_o),
    .ovf_irq_o   (ovf_irq_o),
    .ctl_q       (ctl_q),
    .cnt_q       (cnt_q),
    .cmp_q       (cmp_q)
);

// File: tb/interval_match_timer_tb_top.sv
module interval_match_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       mirq, oirq;

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    logic [11:0] m_pre;
    logic [7:0]  m_cnt, m_cmp;
    logic [1:0]  m_sel, m_mode;
    logic        m_men, m_oen, m_mirq, m_oirq;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_match_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .match_irq_o(mirq), .ovf_irq_o(oirq)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_cmp;
            2'd2: return {m_sel, m_mode, 2'b00, m_oen, m_men};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic tap_hit(input logic [1:0] s, input logic [11:0] p);
        case (s)
            2'd0: return p == 12'hFFF;
            2'd1: return p[7:0] == 8'hFF;
            2'd2: return p[2:0] == 3'h7;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_step(input logic w, input logic [1:0] a, input logic [7:0] d, input logic tk);
        logic clr, pulse;
        clr    = w && a == 2'd2 && d[3];
        pulse  = tk && tap_hit(m_sel, m_pre);
        m_mirq = 1'b0;
        m_oirq = 1'b0;
        if (clr) m_cnt = 8'h00;
        else if (w && a == 2'd0) m_cnt = d;
        else if (pulse) begin
            if (m_mode == 2'b00 && m_cnt == m_cmp) begin
                m_cnt = 8'h00; m_mirq = m_men;
            end else begin
                m_oirq = m_oen && m_cnt == 8'hFF;
                m_cnt  = m_cnt + 8'h01;
            end
        end
        if (clr) m_pre = 12'h000;
        else if (tk) m_pre = m_pre + 12'h001;
        if (w && a == 2'd1) m_cmp = d;
        if (w && a == 2'd2) begin
            m_sel = d[7:6]; m_mode = d[5:4]; m_oen = d[1]; m_men = d[0];
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                        input logic tk, input string tag);
        wr = w; addr = a; wdata = d; tick = tk;
        @(posedge clk);
        @(negedge clk);
        model_step(w, a, d, tk);
        chk({tag, " rdata"}, rdata, exp_read(a));
        chk({tag, " match_irq"}, {7'd0, mirq}, {7'd0, m_mirq});
        chk({tag, " ovf_irq"}, {7'd0, oirq}, {7'd0, m_oirq});
    endtask

    task automatic idle(input int n, input logic [1:0] a, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, a, 8'h00, 1'b1, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seen;
        void'($urandom(32'h1D5E_0A7C));
        m_pre = '0; m_cnt = '0; m_cmp = 8'hFF; m_sel = '0; m_mode = '0;
        m_men = 0; m_oen = 0; m_mirq = 0; m_oirq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values on every address
        chk("R1 ctrl", dut_i.reg_rdata_o, 8'h00);
        for (int a = 0; a < 4; a++) begin
            step(1'b0, a[1:0], 8'h00, 1'b0, "R1");
            chk("R1 direct", rdata, (a == 1) ? 8'hFF : 8'h00);
        end

        // R8 unused address and reference register
        step(1'b1, 2'd3, 8'h5A, 1'b0, "R8");
        step(1'b0, 2'd3, 8'h00, 1'b0, "R8");
        chk("R8 addr3", rdata, 8'h00);
        step(1'b1, 2'd1, 8'h05, 1'b0, "R8");
        step(1'b0, 2'd1, 8'h00, 1'b0, "R8");
        chk("R8 cmp", rdata, 8'h05);

        // R2 div 4096 from clear, mode 01 free run
        step(1'b1, 2'd2, 8'h18, 1'b0, "R7");
        chk("R7 ctrl readback", dut_i.reg_rdata_o, 8'h10);
        idle(4095, 2'd0, "R2");
        chk("R2 slow before", rdata, 8'h00);
        idle(1, 2'd0, "R2");
        chk("R2 slow after", rdata, 8'h01);

        // R2 div 256
        step(1'b1, 2'd2, 8'h58, 1'b0, "R2");
        idle(255, 2'd0, "R2");
        chk("R2 mid before", rdata, 8'h00);
        idle(1, 2'd0, "R2");
        chk("R2 mid after", rdata, 8'h01);

        // R4 R5 div 8, interval mode, match at 5
        step(1'b1, 2'd2, 8'h89, 1'b0, "R4");
        idle(7, 2'd0, "R2");
        chk("R2 fast before", rdata, 8'h00);
        idle(1, 2'd0, "R2");
        chk("R2 fast after", rdata, 8'h01);
        idle(40, 2'd0, "R4");
        chk("R5 match pulse", {7'd0, mirq}, 8'h01);
        chk("R4 cleared", rdata, 8'h00);
        idle(1, 2'd0, "R9");
        chk("R9 pulse ends", {7'd0, mirq}, 8'h00);

        // R5 match disabled: counter still clears, no request
        step(1'b1, 2'd2, 8'h88, 1'b0, "R5");
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            step(1'b0, 2'd0, 8'h00, 1'b1, "R5");
            if (mirq) seen++;
        end
        chk("R5 no match when off", seen[7:0], 8'h00);

        // R6 overflow in free run mode, R8 load
        step(1'b1, 2'd2, 8'h9B, 1'b0, "R6");
        step(1'b1, 2'd0, 8'hFE, 1'b0, "R8");
        chk("R8 load", rdata, 8'hFE);
        seen = 0;
        for (int i = 0; i < 24; i++) begin
            step(1'b0, 2'd0, 8'h00, 1'b1, "R6");
            if (oirq) seen++;
        end
        chk("R6 one overflow", seen[7:0], 8'h01);

        // R3 halt code
        step(1'b1, 2'd0, 8'h42, 1'b0, "R3");
        step(1'b1, 2'd2, 8'hC3, 1'b0, "R3");
        idle(100, 2'd0, "R3");
        chk("R3 held", rdata, 8'h42);

        // R7 clear wins over count, reserved bits read zero
        step(1'b1, 2'd2, 8'h8F, 1'b1, "R7");
        chk("R7 cleared", dut_i.reg_rdata_o, 8'h83);

        // random traffic
        for (int i = 0; i < 30000; i++) begin
            logic w; logic [1:0] a; logic [7:0] d;
            w = ($urandom % 32) == 0;
            a = 2'($urandom);
            d = 8'($urandom);
            if (w && a == 2'd2 && d[7:6] == 2'b00) d[7:6] = 2'b10;
            step(w, a, d, ($urandom % 4) != 0, "R4");
        end

        finish_run();
    end
endmodule